// File: doc/BRIEF.md
# Burst-Capable Bus Slave Responder

This block is a bus slave placed in front of a small on-chip memory. It serves single-beat and burst transfers. A master starts a transfer with a one-cycle start strobe, which carries the start address, the direction, a burst request and the port mode. From then on the slave makes its own beat addresses. It steps the address by one port-sized unit per beat and stops when the address reaches the end of the aligned block. On every beat it returns data or takes in write data, and it marks the beat with an acknowledge.

The port mode selects a 32-, 16- or 8-bit data port, which sets the unit moved per beat and the address bits the slave steps. The master can end a burst early by dropping its more-beats flag. A static mode input makes the slave refuse bursts: it serves only the first unit and raises a refuse flag together with that acknowledge. Address decoding, wait states and error termination are not part of this block.

Top module: `burst_slave`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `beat_ack` and `burst_refuse` are low and `rd_data` is zero.
- R2: A start strobe sampled while no transfer is active gives `beat_ack` high in the next cycle, with one beat per clock after that and no wait states. A start strobe that arrives while `beat_ack` is high is ignored.
- R3: A transfer started with `burst_req` low gets exactly one acknowledge, and `burst_refuse` stays low.
- R4: `port_mode` codes are 0 for a 4-byte unit, 1 for a 2-byte unit and 2 for a 1-byte unit. For an accepted burst, the start byte offset inside the 16-byte block is first rounded down to the unit. The slave then gives (16 - offset)/unit beats, and each beat address is the previous one plus the unit. The burst ends at the block boundary and does not wrap.
- R5: If `more_beats` is low in a cycle where `beat_ack` is high, that beat is the last one, even before the block boundary.
- R6: With `single_only` high, a transfer that requests a burst is served with a single beat, and `burst_refuse` is high in that same cycle and only then.
- R7: On a write beat, the low unit-sized bytes of `wr_data` are stored at the addressed unit, with bits 7:0 going to the lowest byte address. Higher bits of `wr_data` and all other memory bytes are left unchanged.
- R8: On a read beat, the low unit-sized bytes of `rd_data` carry the addressed unit, with the lowest byte address in bits 7:0, and the upper bits are zero. `rd_data` is zero on write beats and when `beat_ack` is low.
- R9: Address, direction, burst request, port mode and `single_only` are used only in the start strobe cycle. Changing them during the beats has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | One-cycle transfer start strobe |
| burst_req | input | 1 | Burst requested (sampled with the strobe) |
| is_read | input | 1 | 1 = read, 0 = write (sampled with the strobe) |
| start_addr | input | AW | Byte start address (sampled with the strobe) |
| port_mode | input | 2 | Port width code: 0 = 32-bit, 1 = 16-bit, 2 = 8-bit |
| single_only | input | 1 | Refuse bursts (sampled with the strobe) |
| more_beats | input | 1 | Master wants more beats after the current one |
| wr_data | input | DW | Write data, valid in acknowledged cycles |
| beat_ack | output | 1 | Beat acknowledge |
| burst_refuse | output | 1 | Burst refused, raised with the first acknowledge |
| rd_data | output | DW | Read data, valid with the acknowledge |

## Verification
The bench builds the block with a 32-bit data bus, 4-word blocks, 16 memory words and an 8-bit address. This gives a 64-byte memory, small enough that a bench model of every byte can be kept. It is also small enough to sweep every start byte of all four blocks under each of the three port modes. The sweep reaches every beat count from one to sixteen and every lane placement. Early termination, refused bursts and changes to the attributes in mid-transfer are then applied on top of the same memory image, so each read also confirms earlier writes.

// File: rtl/bslv_pkg.sv
package bslv_pkg;

  typedef enum logic [1:0] {
    PM_W32 = 2'd0,
    PM_W16 = 2'd1,
    PM_W8  = 2'd2
  } port_mode_e;

  // log2 of the unit size in bytes for a given port mode; codes past the
  // narrowest port fall back to single-byte units
  function automatic int unit_log2(input logic [1:0] mode, input int lane_w);
    if (int'(mode) >= lane_w) return 0;
    return lane_w - int'(mode);
  endfunction

endpackage

// File: rtl/bslv_step.sv
module bslv_step #(
  parameter int OFF_W  = 4,
  parameter int LANE_W = 2
) (
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       mode,
  output logic [OFF_W-1:0] nxt_off,
  output logic             at_end
);
  import bslv_pkg::*;

  logic [OFF_W:0] sum;
  int             ul;

  always_comb begin
    ul      = unit_log2(mode, LANE_W);
    sum     = {1'b0, off} + ((OFF_W+1)'(1) << ul);
    nxt_off = sum[OFF_W-1:0];
    at_end  = sum[OFF_W];
  end

endmodule

// File: rtl/bslv_lanes.sv
module bslv_lanes #(
  parameter int DW = 32
) (
  input  logic [$clog2(DW/8)-1:0] lane,
  input  logic [1:0]              mode,
  input  logic [DW-1:0]           bus_wdata,
  input  logic [DW-1:0]           ram_rword,
  output logic [DW/8-1:0]         lane_en,
  output logic [DW-1:0]           ram_wword,
  output logic [DW-1:0]           bus_rdata
);
  import bslv_pkg::*;

  localparam int BYTES  = DW / 8;
  localparam int LANE_W = $clog2(BYTES);

  int ul;
  int umask;
  int lbase;

  always_comb begin
    ul        = unit_log2(mode, LANE_W);
    umask     = (1 << ul) - 1;
    lbase     = int'(lane) & ~umask;
    lane_en   = '0;
    ram_wword = '0;
    bus_rdata = '0;
    for (int j = 0; j < BYTES; j++) begin
      lane_en[j]          = ((j >> ul) == (lbase >> ul));
      ram_wword[8*j +: 8] = bus_wdata[8*(j & umask) +: 8];
      if (j <= umask)
        bus_rdata[8*j +: 8] = ram_rword[8*((lbase + j) & (BYTES-1)) +: 8];
    end
  end

endmodule

// File: rtl/bslv_ram.sv
module bslv_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic [DW/8-1:0]          we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wword,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rword
);
  localparam int BYTES = DW / 8;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wword[8*g +: 8];
      q <= mem[raddr];
    end
    assign rword[8*g +: 8] = q;
  end

endmodule

// File: rtl/burst_slave.sv
module burst_slave #(
  parameter int DW          = 32,
  parameter int AW          = 16,
  parameter int MEM_WORDS   = 64,
  parameter int BLOCK_WORDS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer_start,
  input  logic          burst_req,
  input  logic          is_read,
  input  logic [AW-1:0] start_addr,
  input  logic [1:0]    port_mode,
  input  logic          single_only,
  input  logic          more_beats,
  input  logic [DW-1:0] wr_data,
  output logic          beat_ack,
  output logic          burst_refuse,
  output logic [DW-1:0] rd_data
);
  import bslv_pkg::*;

  localparam int BYTES     = DW / 8;
  localparam int LANE_W    = $clog2(BYTES);
  localparam int BLK_BYTES = BLOCK_WORDS * BYTES;
  localparam int OFF_W     = $clog2(BLK_BYTES);
  localparam int WIX_W     = $clog2(MEM_WORDS);

  logic          act_q, rd_q, bst_q, refuse_q;
  logic [1:0]    mode_q;
  logic [AW-1:0] cur_q;

  logic [AW-1:0]    start_al, nxt_addr, rd_addr;
  logic [OFF_W-1:0] nxt_off;
  logic             at_end, last_beat;
  logic [BYTES-1:0] lane_en, ram_we;
  logic [DW-1:0]    ram_wword, ram_rword, lane_rdata;
  int               ul_in;

  // start address rounded down to the unit of the requested port
  always_comb begin
    ul_in    = unit_log2(port_mode, LANE_W);
    start_al = start_addr & ~(AW'((1 << ul_in) - 1));
  end

  bslv_step #(.OFF_W(OFF_W), .LANE_W(LANE_W)) u_step (
    .off     (cur_q[OFF_W-1:0]),
    .mode    (mode_q),
    .nxt_off (nxt_off),
    .at_end  (at_end)
  );

  assign nxt_addr  = {cur_q[AW-1:OFF_W], nxt_off};
  assign last_beat = !bst_q || !more_beats || at_end;
  assign rd_addr   = act_q ? nxt_addr : start_al;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      rd_q     <= 1'b0;
      bst_q    <= 1'b0;
      refuse_q <= 1'b0;
      mode_q   <= PM_W32;
      cur_q    <= '0;
    end else if (!act_q) begin
      refuse_q <= 1'b0;
      if (xfer_start) begin
        act_q    <= 1'b1;
        rd_q     <= is_read;
        mode_q   <= port_mode;
        cur_q    <= start_al;
        bst_q    <= burst_req && !single_only;
        refuse_q <= burst_req && single_only;
      end
    end else begin
      refuse_q <= 1'b0;
      if (last_beat) act_q <= 1'b0;
      else           cur_q <= nxt_addr;
    end
  end

  bslv_lanes #(.DW(DW)) u_lanes (
    .lane      (cur_q[LANE_W-1:0]),
    .mode      (mode_q),
    .bus_wdata (wr_data),
    .ram_rword (ram_rword),
    .lane_en   (lane_en),
    .ram_wword (ram_wword),
    .bus_rdata (lane_rdata)
  );

  assign ram_we = (act_q && !rd_q) ? lane_en : '0;

  bslv_ram #(.DW(DW), .DEPTH(MEM_WORDS)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (cur_q[LANE_W +: WIX_W]),
    .wword (ram_wword),
    .raddr (rd_addr[LANE_W +: WIX_W]),
    .rword (ram_rword)
  );

  assign beat_ack     = act_q;
  assign burst_refuse = refuse_q;
  assign rd_data      = (act_q && rd_q) ? lane_rdata : '0;

endmodule

// File: rtl/bslv_chk.sv
module bslv_chk #(
  parameter int BLK_BYTES = 16
) (
  input logic clk,
  input logic rst,
  input logic xfer_start,
  input logic burst_req,
  input logic single_only,
  input logic more_beats,
  input logic beat_ack,
  input logic burst_refuse
);
  localparam int RW = $clog2(BLK_BYTES) + 2;

  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)           run_q <= '0;
    else if (beat_ack) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  // R2
  start_ack_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start && !beat_ack |=> beat_ack);

  // R2
  ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(beat_ack) |-> $past(xfer_start));

  // R3
  single_beat_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start && !burst_req && !beat_ack |=> beat_ack && !burst_refuse ##1 !beat_ack);

  // R4
  max_beats_chk: assert property (@(posedge clk) disable iff (rst)
    beat_ack |-> run_q < RW'(BLK_BYTES));

  // R5
  early_stop_chk: assert property (@(posedge clk) disable iff (rst)
    beat_ack && !more_beats |=> !beat_ack);

  // R6
  refuse_beat_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start && burst_req && single_only && !beat_ack |=> beat_ack && burst_refuse ##1 !beat_ack);

  // R6
  refuse_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
    burst_refuse |-> beat_ack);

endmodule

bind burst_slave bslv_chk #(.BLK_BYTES(BLK_BYTES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .xfer_start   (xfer_start),
  .burst_req    (burst_req),
  .single_only  (single_only),
  .more_beats   (more_beats),
  .beat_ack     (beat_ack),
  .burst_refuse (burst_refuse)
);

// File: tb/burst_slave_tb.sv
`timescale 1ns/1ps
module burst_slave_tb;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int MW = 16;
  localparam int BW = 4;
  localparam int NB = MW * 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          xfer_start = 1'b0, burst_req = 1'b0, is_read = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [1:0]    port_mode = 2'd0;
  logic          single_only = 1'b0, more_beats = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          beat_ack, burst_refuse;
  logic [DW-1:0] rd_data;

  int total = 0, bad = 0, seq = 1;
  bit done = 1'b0;
  logic [7:0] mdl [NB];

  always #10 clk = ~clk;

  burst_slave #(.DW(DW), .AW(AW), .MEM_WORDS(MW), .BLOCK_WORDS(BW)) u_dut (
    .clk(clk), .rst(rst), .xfer_start(xfer_start), .burst_req(burst_req),
    .is_read(is_read), .start_addr(start_addr), .port_mode(port_mode),
    .single_only(single_only), .more_beats(more_beats), .wr_data(wr_data),
    .beat_ack(beat_ack), .burst_refuse(burst_refuse), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one transfer; called and returning at a falling edge
  task automatic xfer(input bit rd, input bit bst, input int a, input int pm,
                      input bit so, input int stop, input bit mut);
    int u, o, base, n, nmax, ba;
    logic [31:0] exp, wd;
    u    = 4 >> pm;
    o    = (a & 15) & ~(u - 1);
    base = a & ~15;
    if (!bst || so) n = 1;
    else begin
      nmax = (16 - o) / u;
      n    = (stop > 0 && stop < nmax) ? stop : nmax;
    end
    xfer_start = 1'b1; burst_req = bst; is_read = rd; start_addr = AW'(a);
    port_mode = 2'(pm); single_only = so; more_beats = 1'b1; wr_data = '0;
    @(negedge clk);
    xfer_start = 1'b0;
    if (mut) begin
      start_addr = AW'(a ^ 8'h2c); is_read = !rd; burst_req = !bst;
      port_mode = 2'((pm + 1) % 3); single_only = !so;
    end
    for (int b = 0; b < n; b++) begin
      ba = base + o + b * u;
      chk("R2 ack on every beat", 32'(beat_ack), 32'd1);
      chk("R6 refuse flag", 32'(burst_refuse), 32'((b == 0) && bst && so));
      if (rd) begin
        exp = '0;
        for (int k = 0; k < u; k++) exp[8*k +: 8] = mdl[ba + k];
        chk(mut ? "R9 read data with changed attributes" : "R8 read data (R7 stored lanes)",
            rd_data, exp);
      end else begin
        wd = 32'h5a000000 ^ (32'(seq) * 32'h01030507);
        seq++;
        wr_data = wd;
        for (int k = 0; k < u; k++) mdl[ba + k] = wd[8*k +: 8];
        chk("R8 read data zero on write beat", rd_data, 32'd0);
      end
      more_beats = !(stop > 0 && b + 1 >= stop);
      xfer_start = mut && (b == 1);
      @(negedge clk);
    end
    xfer_start = 1'b0; more_beats = 1'b0;
    if (stop > 0)          chk("R5 early stop", 32'(beat_ack), 32'd0);
    else if (bst && !so)   chk("R4 stop at block boundary", 32'(beat_ack), 32'd0);
    else                   chk("R3 single acknowledge", 32'(beat_ack), 32'd0);
    chk("R8 read data zero when idle", rd_data, 32'd0);
    chk("R6 refuse low when idle", 32'(burst_refuse), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 ack in reset", 32'(beat_ack), 32'd0);
    chk("R1 refuse in reset", 32'(burst_refuse), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ack after reset", 32'(beat_ack), 32'd0);
    chk("R1 read data after reset", rd_data, 32'd0);

    // R7 fill every block with 32-bit bursts
    for (int blk = 0; blk < 4; blk++) xfer(0, 1, blk * 16, 0, 0, 0, 0);
    // R4 every start byte under every port mode
    for (int pm = 0; pm < 3; pm++)
      for (int a = 0; a < NB; a++) xfer(1, 1, a, pm, 0, 0, 0);
    // R7 narrow write bursts, read back as words
    for (int pm = 1; pm < 3; pm++)
      for (int a = 0; a < NB; a += 5) xfer(0, 1, a, pm, 0, 0, 0);
    for (int a = 0; a < NB; a += 4) xfer(1, 0, a, 0, 0, 0, 0);
    // R3 single-beat writes and reads
    for (int pm = 0; pm < 3; pm++)
      for (int a = 0; a < NB; a += 3) begin
        xfer(0, 0, a, pm, 0, 0, 0);
        xfer(1, 0, a, pm, 0, 0, 0);
      end
    // R6 refused bursts
    for (int pm = 0; pm < 3; pm++)
      for (int a = 1; a < NB; a += 7) begin
        xfer(0, 1, a, pm, 1, 0, 0);
        xfer(1, 1, a, pm, 1, 0, 0);
      end
    // R5 early termination
    for (int pm = 0; pm < 3; pm++)
      for (int s = 1; s < 4; s++) begin
        xfer(1, 1, 0, pm, 0, s, 0);
        xfer(1, 1, 20, pm, 0, s, 0);
      end
    // R9 attributes and a stray start strobe change during beats (R2 ignored)
    for (int pm = 0; pm < 3; pm++)
      foreach (mdl[i]) if (i == 0 || i == 9 || i == 33) begin
        xfer(0, 1, i, pm, 0, 0, 1);
        xfer(1, 1, i, pm, 0, 0, 1);
      end
    for (int a = 0; a < NB; a += 4) xfer(1, 1, a, 0, 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog expired got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule